// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block moves one 24-bit left/right sample pair out on a serial data line and brings one pair in from a second serial line, both within the same frame. The frame is set by a word-select clock (LRCK) and a bit clock (SCLK). The block runs from the master clock (MCLK), which is also the clock of all its flip-flops. As clock master it divides MCLK down to produce SCLK and LRCK. As clock slave it oversamples SCLK and LRCK coming in from outside and follows them.

The data layout in each half frame is chosen by a 2-bit code. There are four layouts: MSB-first left-aligned, the one-bit-delayed I2S layout, and right-aligned with 16 or 24 data bits. A parallel strobe tells the host when a new transmit pair has been taken. A second strobe tells it when a complete received pair is available. Separate enables float the data output and the clock outputs. The block also checks how many MCLK cycles lie between LRCK rising edges. When that count is not a supported ratio, it raises an error and floats the data output.

Top module: `sap_port`

## Requirements
- R1: With `master`=1 and `dbl_speed`=0, `sclk_o` has a period of 4 `clk` cycles and `lrck_o` a period of 256 `clk` cycles. That gives 64 SCLK rising edges per LRCK period. LRCK only changes together with a falling SCLK edge.
- R2: With `master`=1 and `dbl_speed`=1, `lrck_o` has a period of 128 `clk` cycles and `sclk_o` a period of 2 cycles, which still gives 64 SCLK rising edges per frame.
- R3: `fmt`=00 (left-aligned 24-bit). Left is the half where LRCK is high. The first SCLK bit after the LRCK edge carries bit 23 of the word. Bits 22 down to 0 follow, and the rest of the half is 0.
- R4: `fmt`=01 (I2S 24-bit). Left is the half where LRCK is low. The first bit after the LRCK edge is 0, and bit 23 of the word comes one SCLK later.
- R5: `fmt`=11 (right-aligned 24-bit). LRCK high is left. The last 24 bits of the half carry bits 23..0, so bit 0 of the word is the last bit before the next LRCK edge. Earlier bits are 0.
- R6: `fmt`=10 (right-aligned 16-bit). LRCK high is left. The last 16 bits of the half carry word bits 23..8. On receive these land in bits 23..8 and bits 7..0 read 0.
- R7: `sdout` changes only on a falling SCLK edge. `sdin` is sampled on the rising edge, so a serial loopback returns each transmitted bit unchanged.
- R8: `tx_take` pulses for one cycle at the start of each left half, and `tx_left`/`tx_right` are latched in that cycle. One cycle later, `rx_valid` pulses and presents the pair received during the frame just ended. The first `rx_valid` comes only after one full frame has been sent.
- R9: With `master`=0 the block follows `sclk_i`/`lrck_i` at 32 or 64 SCLK per half frame, and `sclk_oe`/`lrck_oe` stay 0.
- R10: `clk_err` is updated at each LRCK rising edge after the first.
  - It is set when the MCLK count since the previous rising edge is not one of the supported ratios: 256, 384, 512, 768 at `dbl_speed`=0, or 128, 192, 256, 384 at `dbl_speed`=1.
  - It is also set when no rising edge arrives for 1023 cycles.
  - While `clk_err` is 1, `sdout_oe` is 0.
- R11: `tri_data`=1 drives `sdout_oe` to 0. `tri_clk`=1 drives `sclk_oe` and `lrck_oe` to 0.
- R12: During reset `sdout`, `sclk_o`, `lrck_o`, `tx_take`, `rx_valid` and `clk_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (MCLK), clocks all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| master | input | 1 | 1: generate SCLK/LRCK, 0: follow external clocks |
| dbl_speed | input | 1 | Speed mode: 0 single (LRCK=MCLK/256), 1 double (MCLK/128) |
| fmt | input | 2 | Data layout code (see R3 to R6) |
| tri_data | input | 1 | Float the serial data output |
| tri_clk | input | 1 | Float the clock outputs |
| sclk_i | input | 1 | Bit clock from outside (slave) |
| lrck_i | input | 1 | Word-select clock from outside (slave) |
| sclk_o | output | 1 | Generated bit clock |
| lrck_o | output | 1 | Generated word-select clock |
| sclk_oe | output | 1 | Output enable for sclk_o |
| lrck_oe | output | 1 | Output enable for lrck_o |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Output enable for sdout |
| tx_left | input | 24 | Left transmit sample |
| tx_right | input | 24 | Right transmit sample |
| tx_take | output | 1 | Pulse: transmit pair latched |
| rx_left | output | 24 | Left received sample |
| rx_right | output | 24 | Right received sample |
| rx_valid | output | 1 | Pulse: received pair valid |
| clk_err | output | 1 | Unsupported MCLK/LRCK ratio seen |

## Verification
The assertions assume that `master`, `dbl_speed` and `fmt` change only while reset is held. They also assume that, in slave mode, LRCK changes only together with a falling SCLK edge. The bench meets both conditions: it sets the configuration with reset asserted, and it builds `sclk_i` and `lrck_i` from a single cycle counter, so the LRCK transitions fall on SCLK falling edges. Loopback runs tie `sdin` to `sdout` through its enable, which keeps the received data a pure delay of the transmitted data.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_LJ24 = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ16 = 2'b10,
    FMT_RJ24 = 2'b11
  } sap_fmt_e;

  // LRCK level that marks the left half of the frame
  function automatic logic left_level(input sap_fmt_e f);
    return (f != FMT_I2S);
  endfunction

  // Map a bit slot to a word bit: {valid, position}
  function automatic logic [5:0] slot_pos(input sap_fmt_e f, input logic [6:0] b,
                                          input logic [6:0] half);
    int bi;
    int hi;
    int s;
    int p;
    logic ok;
    bi = int'(b);
    hi = int'(half);
    ok = 1'b0;
    p  = 0;
    s  = 0;
    case (f)
      FMT_LJ24: if (bi < 24) begin ok = 1'b1; p = 23 - bi; end
      FMT_I2S:  if (bi >= 1 && bi <= 24) begin ok = 1'b1; p = 24 - bi; end
      FMT_RJ16: begin
        s = hi - 16;
        if (s >= 0 && bi >= s && bi < hi) begin ok = 1'b1; p = 23 - (bi - s); end
      end
      default: begin
        s = hi - 24;
        if (s >= 0 && bi >= s && bi < hi) begin ok = 1'b1; p = 23 - (bi - s); end
      end
    endcase
    return {ok, p[4:0]};
  endfunction

  // Supported MCLK cycles per LRCK period
  function automatic logic ratio_ok(input int unsigned n, input logic dbl);
    int unsigned base;
    base = dbl ? 32'd128 : 32'd256;
    return (n == base) || (n == base + base / 2) || (n == 2 * base) || (n == 3 * base);
  endfunction
endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl,
  output logic sclk_int,
  output logic lrck_int
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + DIV_W'(1);
  end

  // single: SCLK=/4, LRCK=/2^DIV_W ; double: SCLK=/2, LRCK=/2^(DIV_W-1)
  assign sclk_int = dbl ? cnt[0] : cnt[1];
  assign lrck_int = dbl ? cnt[DIV_W-2] : cnt[DIV_W-1];

  // R1: word clock moves only with a falling bit clock
  a_r1_lrck_on_sclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck_int) |-> $fell(sclk_int));
endmodule

// File: rtl/sap_edges.sv
module sap_edges #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic sclk_int,
  input  logic lrck_int,
  input  logic sclk_i,
  input  logic lrck_i,
  output logic sclk_o,
  output logic lrck_o,
  output logic lrck_now,
  output logic fall_evt,
  output logic rise_evt,
  output logic lrck_chg,
  output logic lrck_rise
);
  logic [SYNC_N-1:0] s_sh;
  logic [SYNC_N-1:0] l_sh;
  logic sclk_c;
  logic sclk_p;
  logic lrck_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sh <= '0;
      l_sh <= '0;
    end else begin
      s_sh <= {s_sh[SYNC_N-2:0], sclk_i};
      l_sh <= {l_sh[SYNC_N-2:0], lrck_i};
    end
  end

  assign sclk_c   = master ? sclk_int : s_sh[SYNC_N-1];
  assign lrck_now = master ? lrck_int : l_sh[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      lrck_p <= 1'b0;
      sclk_o <= 1'b0;
      lrck_o <= 1'b0;
    end else begin
      sclk_p <= sclk_c;
      lrck_p <= lrck_now;
      // pins lag one cycle so they line up with the data register
      sclk_o <= master & sclk_int;
      lrck_o <= master & lrck_int;
    end
  end

  assign fall_evt  = sclk_p & ~sclk_c;
  assign rise_evt  = ~sclk_p & sclk_c;
  assign lrck_chg  = lrck_p ^ lrck_now;
  assign lrck_rise = ~lrck_p & lrck_now;
endmodule

// File: rtl/sap_ratio_mon.sv
module sap_ratio_mon #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl,
  input  logic lrck_rise,
  output logic clk_err
);
  import sap_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic seen;
  logic sat;

  assign sat = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      seen    <= 1'b0;
      clk_err <= 1'b0;
    end else if (lrck_rise) begin
      cnt  <= CNT_W'(1);
      seen <= 1'b1;
      if (seen) clk_err <= !ratio_ok(int'(cnt), dbl);
    end else if (!sat) begin
      cnt <= cnt + CNT_W'(1);
    end else begin
      clk_err <= 1'b1;
    end
  end

  // R10: the flag only rises on a measured edge or a timeout
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err) |-> $past(lrck_rise || sat));
endmodule

// File: rtl/sap_serdes.sv
module sap_serdes (
  input  logic                          clk,
  input  logic                          rst_n,
  input  sap_pkg::sap_fmt_e             fmt,
  input  logic                          fall_evt,
  input  logic                          rise_evt,
  input  logic                          lrck_chg,
  input  logic                          lrck_now,
  input  logic [sap_pkg::SAMPLE_W-1:0]  tx_left,
  input  logic [sap_pkg::SAMPLE_W-1:0]  tx_right,
  input  logic                          sdin,
  output logic                          sdout,
  output logic                          tx_take,
  output logic [sap_pkg::SAMPLE_W-1:0]  rx_left,
  output logic [sap_pkg::SAMPLE_W-1:0]  rx_right,
  output logic                          rx_valid
);
  import sap_pkg::*;

  logic [6:0] bidx;
  logic [6:0] half_len;
  logic [6:0] b_inc;
  logic [6:0] b_next;
  logic [6:0] half_eff;
  logic [1:0] chg_seen;
  logic       took;
  logic       is_left;
  logic       left_start;
  logic [5:0] tx_pos;
  logic [5:0] rx_pos;
  logic [SAMPLE_W-1:0] sh_l, sh_r, acc_l, acc_r, word;

  assign is_left    = (lrck_now == left_level(fmt));
  assign b_inc      = (bidx == 7'd127) ? bidx : bidx + 7'd1;
  assign b_next     = lrck_chg ? 7'd0 : b_inc;
  assign half_eff   = lrck_chg ? b_inc : half_len;
  assign left_start = fall_evt & lrck_chg & is_left & (chg_seen == 2'd2);
  assign tx_take    = left_start;
  assign word       = left_start ? tx_left : (is_left ? sh_l : sh_r);
  assign tx_pos     = slot_pos(fmt, b_next, half_eff);
  assign rx_pos     = slot_pos(fmt, bidx, half_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx     <= '0;
      half_len <= 7'd32;
      chg_seen <= '0;
      took     <= 1'b0;
      sdout    <= 1'b0;
      sh_l     <= '0;
      sh_r     <= '0;
      acc_l    <= '0;
      acc_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= left_start & took;
      if (fall_evt) begin
        bidx  <= b_next;
        sdout <= tx_pos[5] ? word[tx_pos[4:0]] : 1'b0;
        if (lrck_chg) begin
          half_len <= half_eff;
          if (chg_seen != 2'd2) chg_seen <= chg_seen + 2'd1;
        end
      end
      if (left_start) begin
        sh_l     <= tx_left;
        sh_r     <= tx_right;
        took     <= 1'b1;
        rx_left  <= acc_l;
        rx_right <= acc_r;
        acc_l    <= '0;
        acc_r    <= '0;
      end else if (rise_evt && rx_pos[5]) begin
        if (is_left) acc_l[rx_pos[4:0]] <= sdin;
        else         acc_r[rx_pos[4:0]] <= sdin;
      end
    end
  end

  // R8: a received pair is only delivered right after a transmit latch
  a_r8_rx_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tx_take));
  // R6: 16-bit right-aligned receive leaves the low byte clear
  a_r6_rj16_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fmt == FMT_RJ16) |-> (rx_left[7:0] == 8'h00 && rx_right[7:0] == 8'h00));
endmodule

// File: rtl/sap_port.sv
module sap_port #(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic        dbl_speed,
  input  logic [1:0]  fmt,
  input  logic        tri_data,
  input  logic        tri_clk,
  input  logic        sclk_i,
  input  logic        lrck_i,
  output logic        sclk_o,
  output logic        lrck_o,
  output logic        sclk_oe,
  output logic        lrck_oe,
  input  logic        sdin,
  output logic        sdout,
  output logic        sdout_oe,
  input  logic [23:0] tx_left,
  input  logic [23:0] tx_right,
  output logic        tx_take,
  output logic [23:0] rx_left,
  output logic [23:0] rx_right,
  output logic        rx_valid,
  output logic        clk_err
);
  import sap_pkg::*;

  logic sclk_int, lrck_int, lrck_now;
  logic fall_evt, rise_evt, lrck_chg, lrck_rise;
  sap_fmt_e fmt_e;

  assign fmt_e = sap_fmt_e'(fmt);

  sap_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .dbl(dbl_speed),
    .sclk_int(sclk_int), .lrck_int(lrck_int)
  );

  sap_edges #(.SYNC_N(SYNC_N)) u_edges (
    .clk(clk), .rst_n(rst_n), .master(master),
    .sclk_int(sclk_int), .lrck_int(lrck_int),
    .sclk_i(sclk_i), .lrck_i(lrck_i),
    .sclk_o(sclk_o), .lrck_o(lrck_o), .lrck_now(lrck_now),
    .fall_evt(fall_evt), .rise_evt(rise_evt),
    .lrck_chg(lrck_chg), .lrck_rise(lrck_rise)
  );

  sap_ratio_mon #(.CNT_W(CNT_W)) u_ratio (
    .clk(clk), .rst_n(rst_n), .dbl(dbl_speed),
    .lrck_rise(lrck_rise), .clk_err(clk_err)
  );

  sap_serdes u_serdes (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_e),
    .fall_evt(fall_evt), .rise_evt(rise_evt),
    .lrck_chg(lrck_chg), .lrck_now(lrck_now),
    .tx_left(tx_left), .tx_right(tx_right), .sdin(sdin),
    .sdout(sdout), .tx_take(tx_take),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  assign sclk_oe  = master & ~tri_clk;
  assign lrck_oe  = master & ~tri_clk;
  assign sdout_oe = ~tri_data & ~clk_err;

  // R7: as master, the data line moves only when the bit clock pin falls
  a_r7_sdout_on_sclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(sdout)) |-> $fell(sclk_o));
endmodule

// File: tb/test_sap_port.sv
module test_sap_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1, dbl = 1'b0, tri_d = 1'b0, tri_c = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic sclk_i = 1'b0, lrck_i = 1'b0;
  logic [23:0] tx_left = 24'hA5C3F1, tx_right = 24'h3C5A96;
  logic sclk_o, lrck_o, sclk_oe, lrck_oe, sdin, sdout, sdout_oe;
  logic tx_take, rx_valid, clk_err;
  logic [23:0] rx_left, rx_right;

  int checks = 0;
  int errors = 0;
  int pops = 0;
  bit vary = 0, pend = 0, sb_on = 0;
  bit gen_on = 0, gen_freeze = 0;
  int gen_half = 32;
  int k = 0;
  logic [47:0] q[$];

  always #5 clk = ~clk;

  assign sdin = sdout_oe ? sdout : 1'b0;

  sap_port i_sap_port (
    .clk(clk), .rst_n(rst_n), .master(master), .dbl_speed(dbl), .fmt(fmt),
    .tri_data(tri_d), .tri_clk(tri_c), .sclk_i(sclk_i), .lrck_i(lrck_i),
    .sclk_o(sclk_o), .lrck_o(lrck_o), .sclk_oe(sclk_oe), .lrck_oe(lrck_oe),
    .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe),
    .tx_left(tx_left), .tx_right(tx_right), .tx_take(tx_take),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid), .clk_err(clk_err)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] rx_mask(input logic [23:0] w);
    return (fmt == 2'b10) ? {w[23:8], 8'h00} : w;
  endfunction

  function automatic logic [31:0] exp_slot(input logic [23:0] w);
    case (fmt)
      2'b00:   return {w, 8'h00};
      2'b01:   return {1'b0, w, 7'h00};
      2'b10:   return {16'h0000, w[23:8]};
      default: return {8'h00, w};
    endcase
  endfunction

  // slave clock generator: SCLK = clk/4, LRCK half = gen_half SCLK periods
  initial begin
    forever begin
      @(negedge clk);
      if (gen_on) begin
        k++;
        sclk_i = ((k / 2) % 2) == 1;
        if (!gen_freeze) lrck_i = ((k / (4 * gen_half)) % 2) == 1;
      end
    end
  end

  // driver side of the scoreboard: record each latched pair
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_take) begin
        q.push_back({rx_mask(tx_left), rx_mask(tx_right)});
        if (vary) pend = 1;
      end else if (pend) begin
        tx_left  = tx_left + 24'h35_1A7B;
        tx_right = tx_right ^ {tx_left[11:0], tx_left[23:12]} ^ 24'h81_0042;
        pend = 0;
      end
    end
  end

  // monitor side: compare every delivered pair in order (R8, R7)
  initial begin
    logic [47:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid && sb_on) begin
        pops++;
        if (q.size() == 0) chk(0, "R8 rx without pending tx", {rx_left, rx_right}, 48'h0);
        else begin
          e = q.pop_front();
          chk({rx_left, rx_right} == e, "R7/R8 loopback pair", {rx_left, rx_right}, e);
        end
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic do_reset(input logic m, input logic d, input logic [1:0] f);
    rst_n = 1'b0;
    master = m; dbl = d; fmt = f;
    tri_d = 1'b0; tri_c = 1'b0;
    repeat (3) @(negedge clk);
    q.delete();
    pend = 0;
    rst_n = 1'b1;
  endtask

  task automatic measure(output int per, output int rises);
    logic pl, ps;
    pl = lrck_o;
    while (1) begin
      @(negedge clk);
      if (!pl && lrck_o) break;
      pl = lrck_o;
    end
    per = 0; rises = 0; pl = lrck_o; ps = sclk_o;
    while (1) begin
      @(negedge clk);
      per++;
      if (!ps && sclk_o) rises++;
      ps = sclk_o;
      if (!pl && lrck_o) break;
      pl = lrck_o;
    end
  endtask

  task automatic capture(input logic lvl, output logic [31:0] slot);
    logic pl, ps;
    int i;
    pl = lrck_o;
    while (1) begin
      @(negedge clk);
      if (lrck_o == lvl && pl != lvl) break;
      pl = lrck_o;
    end
    ps = sclk_o; i = 0; slot = '0;
    while (i < 32) begin
      @(negedge clk);
      if (!ps && sclk_o) begin slot = {slot[30:0], sdout}; i++; end
      ps = sclk_o;
    end
  endtask

  task automatic slot_test(input logic [1:0] f, input logic lvl, input string req);
    logic [31:0] s;
    vary = 0; sb_on = 0;
    do_reset(1'b1, 1'b0, f);
    repeat (1200) @(negedge clk);
    capture(lvl, s);
    chk(s == exp_slot(tx_left), req, {16'h0, s}, {16'h0, exp_slot(tx_left)});
  endtask

  task automatic loop_test(input logic m, input logic d, input logic [1:0] f, input int cyc, input string req);
    int p0;
    vary = 1; sb_on = 1;
    do_reset(m, d, f);
    p0 = pops;
    repeat (cyc) @(negedge clk);
    chk((pops - p0) >= 4, req, 48'(pops - p0), 48'd4);
    sb_on = 0; vary = 0;
  endtask

  initial begin
    int per, rises;
    // R12: reset state
    master = 1; dbl = 0; fmt = 2'b00;
    repeat (3) @(negedge clk);
    chk({sdout, sclk_o, lrck_o, tx_take, rx_valid, clk_err} == 6'b0, "R12 reset outputs",
        48'({sdout, sclk_o, lrck_o, tx_take, rx_valid, clk_err}), 48'h0);
    chk(sclk_oe && sdout_oe, "R12 reset enables", 48'({sclk_oe, sdout_oe}), 48'h3);

    // R1 master single-speed clocks
    do_reset(1'b1, 1'b0, 2'b00);
    measure(per, rises);
    chk(per == 256, "R1 lrck period", 48'(per), 48'd256);
    chk(rises == 64, "R1 sclk per frame", 48'(rises), 48'd64);
    chk(clk_err == 1'b0, "R10 master ratio valid", 48'(clk_err), 48'h0);

    // R2 master double-speed clocks
    do_reset(1'b1, 1'b1, 2'b00);
    measure(per, rises);
    chk(per == 128, "R2 lrck period", 48'(per), 48'd128);
    chk(rises == 64, "R2 sclk per frame", 48'(rises), 48'd64);

    // R3..R6 bit placement in the left half as seen on the pins
    slot_test(2'b00, 1'b1, "R3 left-aligned slot");
    slot_test(2'b01, 1'b0, "R4 I2S slot");
    slot_test(2'b11, 1'b1, "R5 right-aligned 24 slot");
    slot_test(2'b10, 1'b1, "R6 right-aligned 16 slot");

    // R7/R8 loopback scoreboard, every format, both speeds
    loop_test(1'b1, 1'b0, 2'b00, 2600, "R8 frames delivered LJ");
    loop_test(1'b1, 1'b0, 2'b01, 2600, "R8 frames delivered I2S");
    loop_test(1'b1, 1'b0, 2'b10, 2600, "R6 frames delivered RJ16");
    loop_test(1'b1, 1'b0, 2'b11, 2600, "R5 frames delivered RJ24");
    loop_test(1'b1, 1'b1, 2'b01, 1400, "R2 frames delivered double");

    // R11 output enables
    do_reset(1'b1, 1'b0, 2'b00);
    tri_d = 1'b1;
    @(negedge clk);
    chk(sdout_oe == 1'b0, "R11 data float", 48'(sdout_oe), 48'h0);
    tri_d = 1'b0; tri_c = 1'b1;
    @(negedge clk);
    chk({sclk_oe, lrck_oe, sdout_oe} == 3'b001, "R11 clock float", 48'({sclk_oe, lrck_oe, sdout_oe}), 48'h1);
    tri_c = 1'b0;

    // R9 slave mode, 32 and 64 SCLK per half
    gen_half = 32; k = 0; gen_on = 1;
    loop_test(1'b0, 1'b0, 2'b00, 3000, "R9 slave 32-bit halves");
    chk(sclk_oe == 1'b0 && lrck_oe == 1'b0, "R9 slave clock enables", 48'({sclk_oe, lrck_oe}), 48'h0);
    chk(clk_err == 1'b0, "R10 ratio 256 ok", 48'(clk_err), 48'h0);
    gen_half = 64; k = 0;
    loop_test(1'b0, 1'b0, 2'b11, 5200, "R9 slave 64-bit halves");
    chk(clk_err == 1'b0, "R10 ratio 512 ok", 48'(clk_err), 48'h0);

    // R10 unsupported ratios
    gen_half = 40; k = 0;
    do_reset(1'b0, 1'b0, 2'b00);
    repeat (1200) @(negedge clk);
    chk(clk_err == 1'b1, "R10 ratio 320 flagged", 48'(clk_err), 48'h1);
    chk(sdout_oe == 1'b0, "R10 error floats data", 48'(sdout_oe), 48'h0);
    gen_half = 16; k = 0;
    do_reset(1'b0, 1'b1, 2'b00);
    repeat (800) @(negedge clk);
    chk(clk_err == 1'b0, "R10 ratio 128 ok at double", 48'(clk_err), 48'h0);
    do_reset(1'b0, 1'b0, 2'b00);
    repeat (800) @(negedge clk);
    chk(clk_err == 1'b1, "R10 ratio 128 flagged at single", 48'(clk_err), 48'h1);
    gen_half = 32; k = 0;
    do_reset(1'b0, 1'b0, 2'b00);
    repeat (900) @(negedge clk);
    chk(clk_err == 1'b0, "R10 before stop", 48'(clk_err), 48'h0);
    gen_freeze = 1;
    repeat (1300) @(negedge clk);
    chk(clk_err == 1'b1, "R10 stopped lrck flagged", 48'(clk_err), 48'h1);
    gen_on = 0; gen_freeze = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule